// File: doc/BRIEF.md
# Digital Audio Output Validity Controller

This block sits in front of a consumer-format digital-audio subframe builder. For every subframe it decides two things per channel. The first is the sample word to send. The second is the validity flag that the builder places at bit 28 of the subframe. It takes the incoming PCM sample for each channel, a flag that says whether that sample actually arrived from the controller, and a per-channel internal transmit-error flag. Two control bits select the policy. The first is a validity-request bit (`vreq_i`). The second is a no-data configuration bit (`nodata_cfg_i`). When set, the no-data bit forces the flag low and zero-pads any channel whose sample is missing.

The decision is registered on each subframe strobe. Each channel is decided on its own inputs only. Between strobes the outputs hold. Biphase coding, preambles, channel status and parity belong to the builder.

Top module: `spdo_validity_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after reset until the first strobe, every word output is zero and every validity output is 0. This matches both control bits resetting to 0.
- R2: In a cycle where `strobe_i` is low, `word_o` and `valid_o` keep their values at the next clock edge.
- R3: On a strobe, a channel whose `got_i` bit is 1 outputs its `sample_i` word on the following cycle, in every mode.
- R4: On a strobe with `vreq_i`=1 and `nodata_cfg_i`=0, each channel's validity output on the following cycle equals that channel's `err_i` bit.
- R5: On a strobe with `nodata_cfg_i`=1, every validity output is 0 on the following cycle, whatever `vreq_i` and `err_i` are. The no-data bit takes priority over the request bit.
- R6: On a strobe with `nodata_cfg_i`=1, a channel whose `got_i` bit is 0 outputs an all-zero word on the following cycle.
- R7: On a strobe with `nodata_cfg_i`=0, a channel whose `got_i` bit is 0 repeats its previous output word.
- R8: On a strobe with `vreq_i`=0 and `nodata_cfg_i`=0, every validity output is 0, whatever `err_i` is.
- R9: Channels are independent. Channel 0 is left and channel 1 is right. One channel's `sample_i`, `got_i` and `err_i` have no effect on the other channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | One-cycle subframe decision strobe |
| vreq_i | input | 1 | Validity-request control bit (report transmit errors) |
| nodata_cfg_i | input | 1 | No-data configuration bit (force flag low, zero-pad missing) |
| sample_i | input | NCH x WORD_W (2x20) | Incoming PCM sample per channel |
| got_i | input | NCH (2) | Sample-received flag per channel |
| err_i | input | NCH (2) | Internal transmit-error flag per channel |
| word_o | output | NCH x WORD_W (2x20) | Audio sample word per channel for the builder |
| valid_o | output | NCH (2) | Validity flag per channel (builder bit 28) |

## Verification
The hardest case to reach is a missing sample whose outcome depends on the word held from an earlier subframe. Under the pass and error-report policies that word is repeated, while under the no-data policy it must be zeroed. The bench therefore plants a known non-zero word on a channel and then starves that channel under each policy in turn. Random stimulus switches policy between strobes and gives each channel its own received and error pattern, which exposes any leakage between channels or any reuse of stale held words.

// File: rtl/spdo_validity_pkg.sv
package spdo_validity_pkg;
  typedef enum logic [1:0] {
    MODE_PASS    = 2'd0,
    MODE_ERR_RPT = 2'd1,
    MODE_PAD_ZERO = 2'd2
  } vmode_e;

  // no-data configuration wins over validity request
  function automatic vmode_e pick_mode(input logic vreq, input logic nodata);
    if (nodata)    return MODE_PAD_ZERO;
    else if (vreq) return MODE_ERR_RPT;
    else           return MODE_PASS;
  endfunction
endpackage

// File: rtl/spdo_mode_dec.sv
module spdo_mode_dec
  import spdo_validity_pkg::*;
(
  input  logic   vreq_i,
  input  logic   nodata_cfg_i,
  output vmode_e mode_o
);
  always_comb mode_o = pick_mode(vreq_i, nodata_cfg_i);
endmodule

// File: rtl/spdo_chan.sv
module spdo_chan
  import spdo_validity_pkg::*;
#(
  parameter int WORD_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  vmode_e            mode_i,
  input  logic [WORD_W-1:0] sample_i,
  input  logic              got_i,
  input  logic              err_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  logic [WORD_W-1:0] word_q, word_d;
  logic              valid_q, valid_d;

  always_comb begin
    word_d  = word_q;
    valid_d = (mode_i == MODE_ERR_RPT) && err_i;
    if (got_i)                        word_d = sample_i;
    else if (mode_i == MODE_PAD_ZERO) word_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else if (strobe_i) begin
      word_q  <= word_d;
      valid_q <= valid_d;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> ($stable(word_o) && $stable(valid_o))); // R2
  AST_PASS_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && got_i) |=> (word_o == $past(sample_i))); // R3
  AST_PAD_MISSING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !got_i && mode_i == MODE_PAD_ZERO) |=> (word_o == '0)); // R6
  AST_REPEAT_MISSING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !got_i && mode_i != MODE_PAD_ZERO) |=> $stable(word_o)); // R7
endmodule

// File: rtl/spdo_validity_ctrl.sv
module spdo_validity_ctrl
  import spdo_validity_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int WORD_W = 20
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         strobe_i,
  input  logic                         vreq_i,
  input  logic                         nodata_cfg_i,
  input  logic [NCH-1:0][WORD_W-1:0]   sample_i,
  input  logic [NCH-1:0]               got_i,
  input  logic [NCH-1:0]               err_i,
  output logic [NCH-1:0][WORD_W-1:0]   word_o,
  output logic [NCH-1:0]               valid_o
);
  vmode_e mode;

  spdo_mode_dec u_dec (
    .vreq_i       (vreq_i),
    .nodata_cfg_i (nodata_cfg_i),
    .mode_o       (mode)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    spdo_chan #(.WORD_W(WORD_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .strobe_i (strobe_i),
      .mode_i   (mode),
      .sample_i (sample_i[c]),
      .got_i    (got_i[c]),
      .err_i    (err_i[c]),
      .word_o   (word_o[c]),
      .valid_o  (valid_o[c])
    );

    AST_ERR_REPORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (strobe_i && vreq_i && !nodata_cfg_i) |=> (valid_o[c] == $past(err_i[c]))); // R4
  end

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (valid_o == '0 && word_o == '0)); // R1
  AST_NODATA_FORCE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && nodata_cfg_i) |=> (valid_o == '0)); // R5
  AST_PASS_MODE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !vreq_i && !nodata_cfg_i) |=> (valid_o == '0)); // R8
endmodule

// File: tb/spdo_validity_ctrl_test.sv
module spdo_validity_ctrl_test;
  localparam int NCH = 2;
  localparam int W   = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic strobe = 1'b0, vreq = 1'b0, nodata = 1'b0;
  logic [NCH-1:0][W-1:0] sample = '0;
  logic [NCH-1:0] got = '0, err = '0;
  logic [NCH-1:0][W-1:0] word;
  logic [NCH-1:0] valid;

  logic [NCH-1:0][W-1:0] exp_word = '0;
  logic [NCH-1:0] exp_valid = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spdo_validity_ctrl #(.NCH(NCH), .WORD_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .strobe_i(strobe), .vreq_i(vreq),
    .nodata_cfg_i(nodata), .sample_i(sample), .got_i(got), .err_i(err),
    .word_o(word), .valid_o(valid)
  );

  function automatic logic f_valid(logic v, logic nd, logic e);
    return (!nd && v) ? e : 1'b0;   // R4 R5 R8
  endfunction

  function automatic logic [W-1:0] f_word(logic nd, logic g, logic [W-1:0] s,
                                          logic [W-1:0] prev);
    if (g)  return s;               // R3
    if (nd) return '0;              // R6
    return prev;                    // R7
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // one clock: model update at posedge, check at negedge
  task automatic step();
    bit stb;
    stb = strobe;
    @(posedge clk);
    if (stb) begin
      for (int c = 0; c < NCH; c++) begin
        exp_valid[c] = f_valid(vreq, nodata, err[c]);
        exp_word[c]  = f_word(nodata, got[c], sample[c], exp_word[c]);
      end
    end
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      string vt, wt;
      if (!stb) begin vt = "R2"; wt = "R2"; end
      else begin
        vt = nodata ? "R5" : (vreq ? "R4" : "R8");
        wt = got[c] ? "R3" : (nodata ? "R6" : "R7");
      end
      chk(vt, 32'(valid[c]), 32'(exp_valid[c]));
      chk(wt, 32'(word[c]),  32'(exp_word[c]));
    end
  endtask

  task automatic drive(bit s, bit v, bit nd, logic [1:0] g, logic [1:0] e,
                       logic [W-1:0] s0, logic [W-1:0] s1);
    strobe = s; vreq = v; nodata = nd; got = g; err = e;
    sample[0] = s0; sample[1] = s1;
    step();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state, even with strobe and data presented
    strobe = 1'b1; got = 2'b11; sample[0] = 20'hABCDE; sample[1] = 20'h12345; vreq = 1; err = 2'b11;
    repeat (2) @(negedge clk);
    chk("R1", 32'(valid), 32'd0);
    chk("R1", 32'(word), 32'd0);
    strobe = 0;
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", 32'(valid), 32'd0);
    chk("R1", {12'd0, word[0]}, 32'd0);

    // plant words, then starve under each policy
    drive(1, 0, 0, 2'b11, 2'b00, 20'h5A5A5, 20'h0F0F0);       // R3
    drive(1, 0, 0, 2'b00, 2'b11, 20'hFFFFF, 20'hFFFFF);       // R7 R8
    drive(1, 1, 0, 2'b00, 2'b01, 20'h11111, 20'h22222);       // R7 R4
    drive(0, 1, 1, 2'b00, 2'b11, 20'h33333, 20'h44444);       // R2
    drive(1, 1, 1, 2'b00, 2'b11, 20'h33333, 20'h44444);       // R5 R6
    // R9: left missing under no-data, right present
    drive(1, 0, 0, 2'b11, 2'b00, 20'h77777, 20'h88888);
    drive(1, 0, 1, 2'b10, 2'b01, 20'h99999, 20'hC3C3C);
    chk("R9", 32'(word[0]), 32'd0);
    chk("R9", 32'(word[1]), 32'hC3C3C);
    // R9: error on right only under error-report
    drive(1, 1, 0, 2'b01, 2'b10, 20'h13579, 20'h2468A);
    chk("R9", 32'(valid), 32'b10);
    chk("R9", 32'(word[1]), 32'hC3C3C);

    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 3) != 0, $urandom % 2, ($urandom % 3) == 0,
            2'($urandom), 2'($urandom), 20'($urandom), 20'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule